// File: doc/BRIEF.md
# Sleep-State Power Sequencing Controller

This block turns two active-low sleep-request lines into a power state and drives the enables for a dual 3.3 V rail and a dual 5 V rail. Each request line is brought into the clock domain by a synchronizer and then deglitched by a counter filter, so a short noise pulse never reaches the state logic. A request to go to sleep is not obeyed at once. A fixed delay timer runs first, and when it expires the suspend line picks which sleep state is entered. A return to active takes effect as soon as both filtered lines are high.

The state register only moves between active and a sleep state. A direct move from suspend-to-RAM to soft-off, or back, is refused. The one illegal line encoding keeps the current state. The power-on-reset input is driven from the standby-supply monitor. It holds the controller in reset until that supply is good, and the first clock after its release raises the standby soft-start enable. A parameter chooses whether the 5 V dual rail stays powered in soft-off.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `state_o` is 00 and all three enables are 0. On the first clock edge after `por_n` goes high, `en_sb_o` and `en_3v3_o` become 1.
- R2: With both request lines high (1,1), the state is active (`state_o` = 00) and both `en_3v3_o` and `en_5v_o` are 1.
- R3: After the `SYNC_STAGES` synchronizer flops, a request line must hold a new level for `FILT_CYC` consecutive clocks before the filter accepts it. A one-clock pulse on a request line has no effect on `state_o`.
- R4: In the active state, a low on `sleep_req_n` starts a delay. `state_o` changes exactly `SYNC_STAGES+FILT_CYC+DELAY_CYC` clocks after the raw line falls. It goes to 01 (suspend) if `off_req_n` is high at that moment, or to 10 (soft-off) if it is low.
- R5: If `sleep_req_n` returns high before the delay expires, the delay is cancelled and the state stays active. A later low starts the full delay again.
- R6: The encoding `sleep_req_n`=1 with `off_req_n`=0 keeps whatever state is current.
- R7: The controller never moves directly between 01 and 10. Holding both lines low in suspend, or `sleep_req_n`=0 with `off_req_n`=1 in soft-off, leaves the state unchanged.
- R8: In suspend, both rail enables are 1. In soft-off, `en_3v3_o` is 1, and `en_5v_o` is 0 when `KEEP_5V_IN_OFF`=0 or 1 when it is 1.
- R9: From either sleep state, driving both lines high returns `state_o` to 00 exactly `SYNC_STAGES+FILT_CYC+1` clocks later, with no delay timer.
- R10: `state_o` never takes the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (the defaults assume a 1 MHz tick) |
| por_n | input | 1 | Synchronous active-low reset, high once the standby supply is valid |
| sleep_req_n | input | 1 | Raw active-low request to leave the active state |
| off_req_n | input | 1 | Raw active-low line that selects soft-off rather than suspend |
| state_o | output | 2 | Power state: 00 active, 01 suspend-to-RAM, 10 soft-off |
| en_sb_o | output | 1 | Standby-rail soft-start enable |
| en_3v3_o | output | 1 | 3.3 V dual rail enable |
| en_5v_o | output | 1 | 5 V dual rail enable |

## Verification
The cases that are hardest to reach from the pins are the forbidden cross moves and the holds, because the sleep state must already be settled when the new pattern arrives. They are also hard to reach because the delay timer sees only filtered levels. The stimulus first walks the state into suspend or soft-off with directed sequences, then applies the cross pattern and checks that nothing moves. Random patterns, each held for longer than the full filter-plus-delay latency, then step through many state pairs, and a bench model at the level of settled transitions predicts each result. Exact-cycle probes on each side of the delay and wake edges pin down the latency, and a delay that is cancelled and then restarted shows that the timer starts over.

// File: rtl/sleep_seq_pkg.sv
// Package: shared power-state encoding for the sleep sequencing controller.
// Assumes the 2-bit codes are decoded outside the block, so they are fixed.
package sleep_seq_pkg;
    typedef enum logic [1:0] {
        PS_ACTIVE = 2'b00,
        PS_SUSP   = 2'b01,
        PS_OFF    = 2'b10
    } pwr_state_e;
endpackage

// File: rtl/sleep_in_cond.sv
// Module: input conditioning for one raw request line. A synchronizer chain
// is followed by a counter deglitch filter. Assumes SYNC_STAGES >= 2 and
// FILT_CYC >= 1. The idle level is high (no request), which is also the
// reset value.
module sleep_in_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic filt_n
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   filt_q;
    logic                   samp;

    // Bring the raw line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_n};
    end

    assign samp = sync_q[SYNC_STAGES-1];

    // Accept a new level only after FILT_CYC consecutive differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else if (samp == filt_q) begin
            cnt_q  <= '0;
        end else if (cnt_q == CW'(FILT_CYC - 1)) begin
            cnt_q  <= '0;
            filt_q <= samp;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign filt_n = filt_q;

    // R3: the filtered level only flips toward a synchronized level that differed
    p_filter_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(samp) == filt_q));
    // R3: the counter never runs past the filter length
    p_filter_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(FILT_CYC));
endmodule

// File: rtl/sleep_fsm.sv
// Module: power-state register with the sleep-entry delay timer. It sees
// only filtered request levels. Leaving active waits DELAY_CYC clocks of a
// steady sleep request, then samples the off line. Wake-up is immediate.
// Assumes DELAY_CYC >= 1.
module sleep_fsm
    import sleep_seq_pkg::*;
#(
    parameter int DELAY_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_n,
    input  logic       off_n,
    output pwr_state_e state_q
);
    localparam int TW = $clog2(DELAY_CYC + 1);

    logic [TW-1:0] tmr_q;
    logic          expire;

    assign expire = (tmr_q == TW'(DELAY_CYC - 1));

    // Delay timer: runs only while active with a sleep request, else cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     tmr_q <= '0;
        else if (state_q == PS_ACTIVE && !sleep_n && !expire) tmr_q <= tmr_q + 1'b1;
        else                                            tmr_q <= '0;
    end

    // State update: enter sleep on expiry, wake only when both lines are high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_ACTIVE;
        end else begin
            case (state_q)
                PS_ACTIVE: if (!sleep_n && expire) state_q <= off_n ? PS_SUSP : PS_OFF;
                PS_SUSP,
                PS_OFF:    if (sleep_n && off_n)   state_q <= PS_ACTIVE;
                default:                           state_q <= PS_ACTIVE;
            endcase
        end
    end

    // R10: the unused code is never taken
    p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'b11);
    // R7: no move from suspend straight to soft-off
    p_no_susp_to_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SUSP) |=> (state_q != PS_OFF));
    // R7: no move from soft-off straight to suspend
    p_no_off_to_susp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OFF) |=> (state_q != PS_SUSP));
    // R5, R6: with the sleep line high, the active state is kept
    p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ACTIVE && sleep_n) |=> (state_q == PS_ACTIVE));
    // R9: both lines high in a sleep state wakes on the next clock
    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_ACTIVE && sleep_n && off_n) |=> (state_q == PS_ACTIVE));
    // R4: the timer stays below the delay length
    p_timer_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q < TW'(DELAY_CYC));
endmodule

// File: rtl/sleep_seq_ctrl.sv
// Module: top of the sleep-state sequencing controller. It conditions both
// request lines, runs the state machine and decodes the rail enables.
// Assumes por_n is already synchronous to clk and goes high only when the
// standby supply is valid.
module sleep_seq_ctrl
    import sleep_seq_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int FILT_CYC       = 2,
    parameter int DELAY_CYC      = 200,
    parameter bit KEEP_5V_IN_OFF = 1'b0
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sleep_req_n,
    input  logic       off_req_n,
    output logic [1:0] state_o,
    output logic       en_sb_o,
    output logic       en_3v3_o,
    output logic       en_5v_o
);
    localparam int NREQ = 2;

    logic [NREQ-1:0] raw_v;
    logic [NREQ-1:0] filt_v;
    pwr_state_e      state;
    logic            sb_q;

    assign raw_v = {off_req_n, sleep_req_n};

    // One conditioning lane per request line.
    for (genvar g = 0; g < NREQ; g++) begin : g_cond
        sleep_in_cond #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYC   (FILT_CYC)
        ) u_cond (
            .clk   (clk),
            .rst_n (por_n),
            .raw_n (raw_v[g]),
            .filt_n(filt_v[g])
        );
    end

    sleep_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
        .clk    (clk),
        .rst_n  (por_n),
        .sleep_n(filt_v[0]),
        .off_n  (filt_v[1]),
        .state_q(state)
    );

    // Standby soft-start enable: raised on the first clock after reset.
    always_ff @(posedge clk) begin
        if (!por_n) sb_q <= 1'b0;
        else        sb_q <= 1'b1;
    end

    assign state_o  = state;
    assign en_sb_o  = sb_q;
    assign en_3v3_o = sb_q;
    assign en_5v_o  = sb_q & ((state != PS_OFF) | KEEP_5V_IN_OFF);

    // R8: suspend keeps both dual rails powered
    p_susp_rails_r8: assert property (@(posedge clk) disable iff (!por_n)
        (state_o == 2'b01) |-> (en_3v3_o && en_5v_o));
    // R1: enables stay low while the reset is held
    p_reset_quiet_r1: assert property (@(posedge clk)
        (!por_n) |=> (!en_sb_o || por_n));
endmodule

// File: tb/sleep_seq_ctrl_test.sv
// Bench: directed corner cases plus seeded random held patterns, with
// expected values from bench functions.
module sleep_seq_ctrl_test;
    localparam int SY = 2, FI = 2, DL = 200;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic s3n = 1'b1, s5n = 1'b1;
    logic [1:0] st, st_alt;
    logic en_sb, en_3v3, en_5v, sb_alt, e33_alt, e5_alt;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sleep_seq_ctrl #(.SYNC_STAGES(SY), .FILT_CYC(FI), .DELAY_CYC(DL), .KEEP_5V_IN_OFF(1'b0)) uut (
        .clk(clk), .por_n(por_n), .sleep_req_n(s3n), .off_req_n(s5n),
        .state_o(st), .en_sb_o(en_sb), .en_3v3_o(en_3v3), .en_5v_o(en_5v));

    sleep_seq_ctrl #(.SYNC_STAGES(SY), .FILT_CYC(FI), .DELAY_CYC(DL), .KEEP_5V_IN_OFF(1'b1)) uut_alt (
        .clk(clk), .por_n(por_n), .sleep_req_n(s3n), .off_req_n(s5n),
        .state_o(st_alt), .en_sb_o(sb_alt), .en_3v3_o(e33_alt), .en_5v_o(e5_alt));

    function automatic logic [1:0] exp_next(logic [1:0] cur, logic a, logic b);
        if (cur == 2'b00 && !a) return b ? 2'b01 : 2'b10;
        if (cur != 2'b00 && a && b) return 2'b00;
        return cur;
    endfunction

    function automatic logic exp_5v(logic [1:0] s, logic keep);
        return (s != 2'b10) || keep;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(logic a, logic b);
        s3n = a; s5n = b;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        tick(200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [1:0] model;
        void'($urandom(32'd1234));
        // R1: reset state
        tick(3);
        chk("R1 state in reset", st, 2'b00);
        chk("R1 enables in reset", {en_sb, en_3v3, en_5v}, 3'b000);
        por_n = 1'b1;
        tick(1);
        chk("R1 standby enable after release", {en_sb, en_3v3}, 2'b11);
        tick(10);
        chk("R2 active rails", {st, en_3v3, en_5v}, {2'b00, 2'b11});

        // R3: one-clock glitch on the sleep line is ignored
        drive(0, 1); tick(1); drive(1, 1);
        tick(300);
        chk("R3 glitch ignored", st, 2'b00);

        // R4: exact delay into suspend
        drive(0, 1);
        tick(SY + FI + DL - 1);
        chk("R4 still active before expiry", st, 2'b00);
        tick(1);
        chk("R4 suspend at expiry", st, 2'b01);
        chk("R8 suspend rails", {en_3v3, en_5v}, 2'b11);

        // R7: both low in suspend does not cross to soft-off
        drive(0, 0); tick(300);
        chk("R7 suspend holds against off", st, 2'b01);
        // R6: illegal code holds suspend
        drive(1, 0); tick(300);
        chk("R6 illegal code holds suspend", st, 2'b01);

        // R9: exact wake latency
        drive(1, 1);
        tick(SY + FI);
        chk("R9 not yet awake", st, 2'b01);
        tick(1);
        chk("R9 awake", st, 2'b00);

        // R6: illegal code in active holds active
        drive(1, 0); tick(300);
        chk("R6 illegal code holds active", st, 2'b00);

        // R5: cancel then full restart
        drive(1, 1); tick(10);
        drive(0, 1); tick(100); drive(1, 1); tick(300);
        chk("R5 cancelled delay stays active", st, 2'b00);
        drive(0, 0);
        tick(SY + FI + DL - 1);
        chk("R5 restart runs full delay", st, 2'b00);
        tick(1);
        chk("R4 soft-off at expiry", st, 2'b10);
        chk("R8 soft-off base rails", {en_3v3, en_5v}, 2'b10);
        chk("R8 soft-off alternate rails", {st_alt, e33_alt, e5_alt}, {2'b10, 2'b11});

        // R7: suspend pattern in soft-off does not cross
        drive(0, 1); tick(300);
        chk("R7 soft-off holds against suspend", st, 2'b10);
        drive(1, 1); tick(20);
        chk("R9 wake from soft-off", st, 2'b00);

        // Random held patterns against the transition model
        model = 2'b00;
        for (int i = 0; i < 40; i++) begin
            logic a, b;
            a = 1'($urandom);
            b = 1'($urandom);
            drive(a, b);
            tick(SY + FI + DL + 20);
            model = exp_next(model, a, b);
            chk("R2/R4/R6/R7/R9 random state", st, model);
            chk("R8 random 5V rail", en_5v, exp_5v(model, 1'b0));
            chk("R10 legal code", st == 2'b11, 1'b0);
        end
        summary();
    end
endmodule